// File: doc/BRIEF.md
# Multiplexed Segment LCD Controller with Pixel Blink

This block is the digital sequencer for a segment LCD driven at 1/4 duty through four common lines. A slow timing tick, derived from a 32768 Hz clock, steps a scan counter through the four commons. For the active common, each segment output shows the matching bit of that segment's 4-bit display word. The drive polarity inverts on every other frame, so the glass sees no net DC voltage. Analog bias levels and pad drivers sit outside the block. They turn the logic levels produced here into panel voltages.

Two segment positions, chosen by parameter, can blink. Each has a 4-bit mask with one bit per common. During the off half of the blink period, the pixels whose mask bit is set are forced to the unlit level. A single rate bit selects a blink period of 2 s (0.5 Hz) or 1 s (1 Hz). Each pin can also be handed to general-purpose digital I/O through a per-pin mode bitmap. A pin in I/O duty takes its enable and value from the I/O registers, and its segment output is held low.

Top module: `lcd_mux_ctrl`

## Requirements
- R1: After reset, common 0 is active (`com_act` = 4'b0001), `frame_pol` is 0, and the blink phase is in its on half.
- R2: The active common advances by one every COM_TICKS ticks and cycles 0,1,2,3,0. `com_act` is one-hot, and bit n means common n is active.
- R3: While `tick` is low, the scan position, the frame polarity and the blink phase do not change.
- R4: `frame_pol` inverts at the step where common 3 hands over to common 0, and at no other step.
- R5: For a segment pin in LCD mode, `seg_out[s]` equals bit `seg_data[4*s + c]` XOR `frame_pol`, where c is the active common. A 1 in the data bit means lit, and an unlit segment sits at the `frame_pol` level.
- R6: On the two blink segments BLINK_A and BLINK_B, during the off half of the blink period, a pixel whose mask bit c is set (bit 3 = common 3, bit 0 = common 0) is driven unlit (`seg_out` = `frame_pol`). During the on half it shows its data.
- R7: The blink phase toggles after TICK_HZ ticks when `blink_slow` = 1 (0.5 Hz) and after TICK_HZ/2 ticks when `blink_slow` = 0 (1 Hz).
- R8: Segments other than BLINK_A and BLINK_B never blink, whatever the blink masks hold.
- R9: A pin with `pin_is_dio[s]` = 1 drives `seg_out[s]` = 0, `pin_oe[s]` = `dio_oe[s]` and `pin_do[s]` = `dio_out[s]`. A pin in LCD mode drives `pin_oe[s]` = 0 and `pin_do[s]` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle timing strobe derived from the 32768 Hz clock |
| seg_data | input | 4*NUM_SEG | Display words, 4 bits per segment, bit c for common c |
| pin_is_dio | input | NUM_SEG | Per-pin mode, 1 = digital I/O, 0 = LCD segment |
| dio_oe | input | NUM_SEG | Output enable for pins in I/O duty |
| dio_out | input | NUM_SEG | Output value for pins in I/O duty |
| blink_slow | input | 1 | Blink rate, 1 = 0.5 Hz, 0 = 1 Hz |
| blink_mask_a | input | 4 | Blink mask for segment BLINK_A |
| blink_mask_b | input | 4 | Blink mask for segment BLINK_B |
| com_act | output | 4 | One-hot active common |
| frame_pol | output | 1 | Current frame polarity |
| seg_out | output | NUM_SEG | Segment logic levels |
| pin_oe | output | NUM_SEG | Pad output enable for I/O duty |
| pin_do | output | NUM_SEG | Pad output value for I/O duty |

## Verification
The first pattern is a display word with no repeating bits per segment, run over several frames with the tick held high. It separates a wrong common-to-bit mapping from a missing polarity inversion. All-ones data under complementary masks on the two blink segments, run at both rate settings, shows whether the right pixels blink, whether the mask bit order is correct and whether the half-period length is right. It also shows any leak of blinking into other segments. A tick-free stretch and a mixed pin-mode bitmap, with I/O enable and value differing from the segment data, show stalls and I/O override separately.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
    localparam int NUM_COM = 4;
    localparam int COM_W   = $clog2(NUM_COM);
    typedef logic [COM_W-1:0] com_idx_t;
endpackage

// File: rtl/lcd_scan.sv
module lcd_scan import lcd_pkg::*; #(
    parameter int COM_TICKS = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    output com_idx_t com_idx,
    output logic     frame_pol
);
    localparam int DW = (COM_TICKS > 1) ? $clog2(COM_TICKS) : 1;

    typedef struct packed {
        logic [DW-1:0] div;
        com_idx_t      com;
        logic          pol;
    } scan_t;

    scan_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (st_q.div == DW'(COM_TICKS - 1)) begin
                st_d.div = '0;
                st_d.com = st_q.com + 1'b1;
                if (st_q.com == com_idx_t'(NUM_COM - 1))
                    st_d.pol = ~st_q.pol;
            end else begin
                st_d.div = st_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign com_idx   = st_q.com;
    assign frame_pol = st_q.pol;

    assert_com_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.com) |-> (st_q.com == com_idx_t'($past(st_q.com) + 1'b1)));
    assert_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> ($stable(st_q.com) && $stable(st_q.pol)));
    assert_pol_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.pol) |-> ($past(st_q.com) == com_idx_t'(NUM_COM - 1) && st_q.com == '0));
endmodule

// File: rtl/lcd_blink.sv
module lcd_blink #(
    parameter int TICK_HZ = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic blink_slow,
    output logic blink_off
);
    localparam int CW = $clog2(TICK_HZ) + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          off;
    } blink_t;

    blink_t bk_d, bk_q;
    logic [CW-1:0] limit;

    always_comb begin
        limit = blink_slow ? CW'(TICK_HZ - 1) : CW'(TICK_HZ / 2 - 1);
        bk_d  = bk_q;
        if (tick) begin
            if (bk_q.cnt >= limit) begin
                bk_d.cnt = '0;
                bk_d.off = ~bk_q.off;
            end else begin
                bk_d.cnt = bk_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign blink_off = bk_q.off;

    assert_blink_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> $stable(bk_q.off));
    assert_blink_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bk_q.off) |-> ($past(bk_q.cnt) >= CW'(TICK_HZ / 2 - 1)));
endmodule

// File: rtl/lcd_seg_drive.sv
module lcd_seg_drive import lcd_pkg::*; #(
    parameter int NUM_SEG = 24,
    parameter int BLINK_A = 18,
    parameter int BLINK_B = 19
) (
    input  com_idx_t                     com_idx,
    input  logic                         frame_pol,
    input  logic                         blink_off,
    input  logic [NUM_COM*NUM_SEG-1:0]   seg_data,
    input  logic [NUM_SEG-1:0]           pin_is_dio,
    input  logic [NUM_SEG-1:0]           dio_oe,
    input  logic [NUM_SEG-1:0]           dio_out,
    input  logic [NUM_COM-1:0]           blink_mask_a,
    input  logic [NUM_COM-1:0]           blink_mask_b,
    output logic [NUM_SEG-1:0]           seg_out,
    output logic [NUM_SEG-1:0]           pin_oe,
    output logic [NUM_SEG-1:0]           pin_do
);
    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        logic [NUM_COM-1:0] word;
        logic               pix;
        logic               blank;
        assign word = seg_data[s*NUM_COM +: NUM_COM];

        if (s == BLINK_A) begin : g_blink_a
            assign blank = blink_off & blink_mask_a[com_idx];
        end else if (s == BLINK_B) begin : g_blink_b
            assign blank = blink_off & blink_mask_b[com_idx];
        end else begin : g_steady
            assign blank = 1'b0;
        end

        always_comb begin
            pix        = word[com_idx] & ~blank;
            seg_out[s] = pin_is_dio[s] ? 1'b0 : (pix ^ frame_pol);
            pin_oe[s]  = pin_is_dio[s] & dio_oe[s];
            pin_do[s]  = pin_is_dio[s] & dio_out[s];
        end
    end
endmodule

// File: rtl/lcd_mux_ctrl.sv
module lcd_mux_ctrl import lcd_pkg::*; #(
    parameter int NUM_SEG   = 24,
    parameter int BLINK_A   = 18,
    parameter int BLINK_B   = 19,
    parameter int COM_TICKS = 8,
    parameter int TICK_HZ   = 32768
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic [NUM_COM*NUM_SEG-1:0] seg_data,
    input  logic [NUM_SEG-1:0]         pin_is_dio,
    input  logic [NUM_SEG-1:0]         dio_oe,
    input  logic [NUM_SEG-1:0]         dio_out,
    input  logic                       blink_slow,
    input  logic [NUM_COM-1:0]         blink_mask_a,
    input  logic [NUM_COM-1:0]         blink_mask_b,
    output logic [NUM_COM-1:0]         com_act,
    output logic                       frame_pol,
    output logic [NUM_SEG-1:0]         seg_out,
    output logic [NUM_SEG-1:0]         pin_oe,
    output logic [NUM_SEG-1:0]         pin_do
);
    com_idx_t com_idx;
    logic     blink_off;

    lcd_scan #(.COM_TICKS(COM_TICKS)) u_scan (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .com_idx(com_idx), .frame_pol(frame_pol)
    );

    lcd_blink #(.TICK_HZ(TICK_HZ)) u_blink (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .blink_slow(blink_slow), .blink_off(blink_off)
    );

    lcd_seg_drive #(.NUM_SEG(NUM_SEG), .BLINK_A(BLINK_A), .BLINK_B(BLINK_B)) u_drive (
        .com_idx(com_idx), .frame_pol(frame_pol), .blink_off(blink_off),
        .seg_data(seg_data), .pin_is_dio(pin_is_dio),
        .dio_oe(dio_oe), .dio_out(dio_out),
        .blink_mask_a(blink_mask_a), .blink_mask_b(blink_mask_b),
        .seg_out(seg_out), .pin_oe(pin_oe), .pin_do(pin_do)
    );

    always_comb begin
        com_act = '0;
        com_act[com_idx] = 1'b1;
    end

    assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(com_act));
    assert_dio_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_out & pin_is_dio) == '0);
    assert_lcd_pad_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe | pin_do) & ~pin_is_dio) == '0);
    assert_blank_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_off && blink_mask_a[com_idx] && !pin_is_dio[BLINK_A])
        |-> (seg_out[BLINK_A] == frame_pol));
endmodule

// File: tb/lcd_mux_ctrl_bench.sv
module lcd_mux_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 6;
    localparam int BA = 1;
    localparam int BB = 4;
    localparam int CT = 2;
    localparam int HZ = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [4*NS-1:0] seg_data = '0;
    logic [NS-1:0] pin_is_dio = '0, dio_oe = '0, dio_out = '0;
    logic blink_slow = 1'b0;
    logic [3:0] mask_a = '0, mask_b = '0;
    logic [3:0] com_act;
    logic frame_pol;
    logic [NS-1:0] seg_out, pin_oe, pin_do;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_mux_ctrl #(.NUM_SEG(NS), .BLINK_A(BA), .BLINK_B(BB), .COM_TICKS(CT), .TICK_HZ(HZ))
    u_lcd_mux_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .seg_data(seg_data),
        .pin_is_dio(pin_is_dio), .dio_oe(dio_oe), .dio_out(dio_out),
        .blink_slow(blink_slow), .blink_mask_a(mask_a), .blink_mask_b(mask_b),
        .com_act(com_act), .frame_pol(frame_pol), .seg_out(seg_out),
        .pin_oe(pin_oe), .pin_do(pin_do)
    );

    typedef struct {
        string tag_st;
        string tag_seg;
        logic [3:0] com;
        logic pol;
        logic [NS-1:0] seg, oe, dout;
    } exp_t;

    exp_t q[$];
    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    string ph_st = "R1", ph_seg = "R1";

    int m_div = 0, m_com = 0, m_bcnt = 0;
    bit m_pol = 0, m_off = 0;

    task automatic model_step();
        int lim;
        if (!rst_n) begin
            m_div = 0; m_com = 0; m_pol = 0; m_bcnt = 0; m_off = 0;
        end else if (tick) begin
            if (m_div == CT - 1) begin
                m_div = 0;
                if (m_com == 3) m_pol = ~m_pol;
                m_com = (m_com + 1) % 4;
            end else m_div++;
            lim = blink_slow ? HZ - 1 : HZ / 2 - 1;
            if (m_bcnt >= lim) begin m_bcnt = 0; m_off = ~m_off; end
            else m_bcnt++;
        end
    endtask

    task automatic cycle();
        exp_t e;
        @(posedge clk);
        model_step();
        #3;
        e.tag_st = ph_st; e.tag_seg = ph_seg;
        e.com = 4'b0001 << m_com;
        e.pol = m_pol;
        for (int s = 0; s < NS; s++) begin
            bit pix, blank;
            pix = seg_data[4*s + m_com];
            blank = m_off && ((s == BA && mask_a[m_com]) || (s == BB && mask_b[m_com]));
            if (blank) pix = 0;
            e.seg[s]  = pin_is_dio[s] ? 1'b0 : (pix ^ m_pol);
            e.oe[s]   = pin_is_dio[s] ? dio_oe[s] : 1'b0;
            e.dout[s] = pin_is_dio[s] ? dio_out[s] : 1'b0;
        end
        q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (com_act !== e.com) begin
                n_bad++; $display("FAIL %s com_act actual=%b expected=%b", e.tag_st, com_act, e.com);
            end
            if (frame_pol !== e.pol) begin
                n_bad++; $display("FAIL %s frame_pol actual=%b expected=%b", e.tag_st, frame_pol, e.pol);
            end
            if (seg_out !== e.seg) begin
                n_bad++; $display("FAIL %s seg_out actual=%b expected=%b", e.tag_seg, seg_out, e.seg);
            end
            if (pin_oe !== e.oe || pin_do !== e.dout) begin
                n_bad++; $display("FAIL R9 pin_oe/pin_do actual=%b/%b expected=%b/%b",
                                  pin_oe, pin_do, e.oe, e.dout);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); #1;
        seg_data = 24'hA5C3F0;
        // R1: reset state
        run(3);
        rst_n = 1'b1;
        // R2, R4, R5: free-running scan with a mixed pattern
        ph_st = "R2"; ph_seg = "R5"; tick = 1'b1;
        run(40);
        seg_data = 24'h3C96E1;
        ph_st = "R4";
        run(24);
        // R3: stall without tick
        ph_st = "R3"; tick = 1'b0;
        run(10);
        tick = 1'b1; ph_st = "R2";
        // R6: blink at 1 Hz with complementary masks
        seg_data = '1; mask_a = 4'b0101; mask_b = 4'b1010; blink_slow = 1'b0;
        ph_seg = "R6";
        run(40);
        // R7: slow blink rate
        blink_slow = 1'b1; ph_seg = "R7";
        run(80);
        // R8: masks fully set, other segments must not blink
        mask_a = 4'b1111; mask_b = 4'b1111; ph_seg = "R8";
        run(40);
        // R9: mixed pin modes
        pin_is_dio = 6'b100110; dio_oe = 6'b110100; dio_out = 6'b011110;
        ph_seg = "R9";
        run(20);
        dio_oe = 6'b001011; dio_out = 6'b100101; seg_data = 24'h5A5A5A;
        run(12);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule